// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Controller

This block raises a message to a power modulo an odd modulus, C = P^e mod m. It uses binary exponentiation, and every multiplication inside it is a radix-2 Montgomery product with R = 2^k, where k is the key width. The caller supplies P, e, m and the constant K = R^2 mod m, then pulses `start`. When the result is ready, `done` pulses and the result appears on `result`. Encryption and decryption are the same operation: the caller passes the public exponent for one and the private exponent for the other.

The exponent is consumed one bit per round, least significant bit first. Two Montgomery multipliers work side by side. In each round, one squares the running power of P. The other multiplies that power into the accumulator, but only when the current exponent bit is 1. A first round moves 1 and P into the Montgomery domain. A last round multiplies the accumulator by plain 1 to bring it back out. Every product is fully reduced into [0, m) before it is used.

Top module: `mx_modexp`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `result` is 0.
- R2: For an odd modulus 1 <= m < 2^k, a message P < m and K = 2^(2k) mod m, the result equals P^e mod m. With k = 10, m = 323 and e = 11, P = 15 gives 60. With e = 131, P = 60 gives 15.
- R3: Every value presented on `result` with `done` is smaller than m.
- R4: `done` rises exactly (k+2)(k+3) clock edges after the edge that samples `start` in the idle state. That is k+2 multiplication rounds of k+3 cycles each.
- R5: `done` is high for exactly one cycle. `result` keeps its value until the next completion.
- R6: A `start` pulse while `busy` is 1 is ignored. The running operation finishes with its own operands and on its own schedule, and no extra operation follows it.
- R7: Exponent bits that are 0 leave the accumulator unchanged. An all-zero exponent yields 1 mod m, which is 1 for m > 1 and 0 for m = 1.
- R8: Exponent bit i, counted from bit 0 (the least significant), selects the factor P^(2^i). An exponent with only bit k-1 set gives P^(2^(k-1)) mod m.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an exponentiation; sampled only when idle |
| msg_in | input | KW | Message P, smaller than m |
| exp_in | input | KW | Exponent (public or private key) |
| mod_in | input | KW | Odd modulus m |
| rsq_in | input | KW | Constant 2^(2k) mod m |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | KW | P^e mod m |

## Verification
The bench uses a 10-bit key. It sweeps every message below 323 with exponent 11. This cross-checks each message against its own arithmetic reference, and any wrong partial product or carry in the multipliers shows up as a mismatch. Pseudo-random messages and exponents over several moduli then separate correct bit ordering and squaring from schedules that only happen to work for one exponent. These include a tiny modulus, one just below 2^k, and m = 1. Zero exponents, a lone top bit, and a start pulse injected mid-run isolate the scan bookkeeping: the hold on 0 bits, the round count, and ignoring requests while busy. The completion pulse is timed against the (k+2)(k+3) schedule on every run.

// File: rtl/mx_pkg.sv
package mx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_SCAN  = 2'd2,
    ST_LEAVE = 2'd3
  } mx_state_e;
endpackage

// File: rtl/mx_mont_mul.sv
module mx_mont_mul #(
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [KW-1:0] a,
  input  logic [KW-1:0] b,
  input  logic [KW-1:0] m,
  output logic [KW-1:0] res,
  output logic          fin,
  output logic          busy
);
  localparam int SW = KW + 2;
  localparam int CW = $clog2(KW + 1);

  logic [SW-1:0] s_q;
  logic [KW-1:0] a_q;
  logic [KW-1:0] b_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  // one radix-2 Montgomery step: add the partial product, then make even and halve
  function automatic logic [SW-1:0] mont_step(input logic [SW-1:0] s,
                                              input logic [KW-1:0] av,
                                              input logic bit_i,
                                              input logic [KW-1:0] mv);
    logic [SW-1:0] t;
    logic [SW-1:0] u;
    t = s + (bit_i ? {2'b00, av} : '0);
    u = t + (t[0] ? {2'b00, mv} : '0);
    return u >> 1;
  endfunction

  function automatic logic [KW-1:0] reduce_once(input logic [SW-1:0] s,
                                                input logic [KW-1:0] mv);
    logic [SW-1:0] d;
    d = s - {2'b00, mv};
    return (s >= {2'b00, mv}) ? d[KW-1:0] : s[KW-1:0];
  endfunction

  assign last_step = (cnt_q == CW'(KW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
      res   <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        s_q   <= '0;
        a_q   <= a;
        b_q   <= b;
        cnt_q <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        if (last_step) begin
          res  <= reduce_once(s_q, m);
          fin  <= 1'b1;
          busy <= 1'b0;
        end else begin
          s_q   <= mont_step(s_q, a_q, b_q[0], m);
          b_q   <= b_q >> 1;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_MM_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);  // R4
  AST_MM_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);  // R5
  AST_MM_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && m != '0) |-> (res < m));  // R3
endmodule

// File: rtl/mx_exp_scan.sv
module mx_exp_scan #(
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [KW-1:0] exp_in,
  input  logic          adv,
  output logic          cur_bit,
  output logic          nxt_bit,
  output logic          last
);
  localparam int CW = $clog2(KW + 1);

  logic [KW-1:0] sh_q;
  logic [CW-1:0] rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rnd_q <= '0;
    end else if (load) begin
      sh_q  <= exp_in;
      rnd_q <= '0;
    end else if (adv) begin
      sh_q  <= sh_q >> 1;
      rnd_q <= rnd_q + 1'b1;
    end
  end

  assign cur_bit = sh_q[0];
  assign last    = (rnd_q == CW'(KW - 1));

  generate
    if (KW > 1) begin : g_next
      assign nxt_bit = sh_q[1];
    end else begin : g_single
      assign nxt_bit = 1'b0;
    end
  endgenerate

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (rnd_q < CW'(KW)));  // R8
endmodule

// File: rtl/mx_modexp.sv
module mx_modexp #(
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] msg_in,
  input  logic [KW-1:0] exp_in,
  input  logic [KW-1:0] mod_in,
  input  logic [KW-1:0] rsq_in,
  output logic          busy,
  output logic          done,
  output logic [KW-1:0] result
);
  import mx_pkg::*;

  localparam int LAT = (KW + 2) * (KW + 3);
  localparam int LW  = $clog2(LAT + 1);
  localparam logic [KW-1:0] ONE = KW'(1);

  mx_state_e     state_q;
  logic [KW-1:0] z_q, p_q, m_q, k_q;
  logic [1:0]    go_q;
  logic [KW-1:0] op_a [2];
  logic [KW-1:0] op_b [2];
  logic [KW-1:0] prod [2];
  logic [1:0]    fin;
  logic [1:0]    mbusy;
  logic          accept, scan_adv, cur_bit, nxt_bit, last_rnd;
  logic [LW-1:0] cyc_q;

  assign accept   = (state_q == ST_IDLE) && start;
  assign scan_adv = (state_q == ST_SCAN) && fin[1];
  assign busy     = (state_q != ST_IDLE);

  always_comb begin
    op_a[0] = '0; op_b[0] = '0;
    op_a[1] = '0; op_b[1] = '0;
    case (state_q)
      ST_ENTER: begin
        op_a[0] = ONE; op_b[0] = k_q;
        op_a[1] = p_q; op_b[1] = k_q;
      end
      ST_SCAN: begin
        op_a[0] = z_q; op_b[0] = p_q;
        op_a[1] = p_q; op_b[1] = p_q;
      end
      ST_LEAVE: begin
        op_a[0] = z_q; op_b[0] = ONE;
      end
      default: ;
    endcase
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_mul
      mx_mont_mul #(.KW(KW)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go_q[g]),
        .a    (op_a[g]),
        .b    (op_b[g]),
        .m    (m_q),
        .res  (prod[g]),
        .fin  (fin[g]),
        .busy (mbusy[g])
      );
    end
  endgenerate

  mx_exp_scan #(.KW(KW)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .exp_in (exp_in),
    .adv    (scan_adv),
    .cur_bit(cur_bit),
    .nxt_bit(nxt_bit),
    .last   (last_rnd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      z_q     <= '0;
      p_q     <= '0;
      m_q     <= '0;
      k_q     <= '0;
      go_q    <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      go_q <= '0;
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          p_q     <= msg_in;
          m_q     <= mod_in;
          k_q     <= rsq_in;
          go_q    <= 2'b11;
          state_q <= ST_ENTER;
        end
        ST_ENTER: if (fin[1]) begin
          z_q     <= prod[0];
          p_q     <= prod[1];
          go_q    <= {1'b1, cur_bit};
          state_q <= ST_SCAN;
        end
        ST_SCAN: if (fin[1]) begin
          if (cur_bit) z_q <= prod[0];
          p_q <= prod[1];
          if (last_rnd) begin
            go_q    <= 2'b01;
            state_q <= ST_LEAVE;
          end else begin
            go_q <= {1'b1, nxt_bit};
          end
        end
        ST_LEAVE: if (fin[0]) begin
          result  <= prod[0];
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // cycle counter used only by the latency assertion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (accept) cyc_q <= '0;
    else if (busy)   cyc_q <= cyc_q + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R5
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_q != '0) |-> (result < m_q));  // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == LW'(LAT)));  // R4
  AST_BUSY_KEEPS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(m_q));  // R6
  AST_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_adv && !cur_bit) |=> $stable(z_q));  // R7
endmodule

// File: tb/mx_modexp_tb.sv
module mx_modexp_tb;
  localparam int KW  = 10;
  localparam int LAT = (KW + 2) * (KW + 3);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [KW-1:0] msg_in = '0, exp_in = '0, mod_in = '0, rsq_in = '0;
  logic          busy, done;
  logic [KW-1:0] result;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mx_modexp #(.KW(KW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_in(msg_in), .exp_in(exp_in),
    .mod_in(mod_in), .rsq_in(rsq_in), .busy(busy), .done(done), .result(result)
  );

  function automatic longint ref_pow(longint b, longint e, longint m);
    longint r = 1 % m;
    longint x = b % m;
    while (e > 0) begin
      if (e % 2 == 1) r = (r * x) % m;
      x = (x * x) % m;
      e = e / 2;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one exponentiation; optionally a stray start pulse is injected mid-run
  task automatic run_op(input int p, input int e, input int m, input bit stray);
    int cnt;
    longint expv;
    logic [KW-1:0] held;
    expv = ref_pow(p, e, m);
    @(negedge clk);
    msg_in = KW'(p); exp_in = KW'(e); mod_in = KW'(m);
    rsq_in = KW'((longint'(1) << (2 * KW)) % m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < LAT + 20) begin
      @(negedge clk);
      cnt++;
      if (stray && cnt == 20) begin
        msg_in = KW'((p + 1) % m); exp_in = KW'(e + 3); start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(result == KW'(expv), "R2", result, expv);
    chk(cnt == LAT, "R4", cnt, LAT);
    chk(result < KW'(m) || m == 0, "R3", result, m);
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R5", done, 0);
    chk(result == held, "R5", result, held);
    if (stray) begin
      for (int i = 0; i < 4; i++) begin
        chk(!busy && !done, "R6", {busy, done}, 0);
        @(negedge clk);
      end
      chk(result == KW'(expv), "R6", result, expv);
    end
  endtask

  initial begin
    int seed;
    int mods [5] = '{323, 1021, 3, 513, 997};
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R1", {busy, done}, 0);
    chk(result == '0, "R1", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // example from the requirement (R2)
    run_op(15, 11, 323, 1'b0);
    chk(result == 10'd60, "R2", result, 60);
    run_op(60, 131, 323, 1'b0);
    chk(result == 10'd15, "R2", result, 15);
    // ignored start (R6)
    run_op(15, 11, 323, 1'b1);
    // zero exponent and modulus one (R7)
    run_op(200, 0, 323, 1'b0);
    chk(result == 10'd1, "R7", result, 1);
    run_op(0, 0, 1, 1'b0);
    chk(result == 10'd0, "R7", result, 0);
    run_op(0, 5, 323, 1'b0);
    // lone top bit (R8)
    run_op(7, 1 << (KW - 1), 1021, 1'b0);
    run_op(2, 1 << (KW - 1), 323, 1'b0);
    // exhaustive message sweep for m = 323 (R2)
    for (int p = 0; p < 323; p++) run_op(p, 11, 323, 1'b0);
    // pseudo-random messages and exponents over several moduli (R2, R7)
    seed = 12345;
    for (int j = 0; j < 5; j++) begin
      for (int n = 0; n < 60; n++) begin
        int pp, ee;
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        pp = (seed >>> 8) % mods[j];
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        ee = (seed >>> 5) % (1 << KW);
        run_op(pp, ee, mods[j], 1'b0);
      end
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule